// File: doc/BRIEF.md
# Edge-Counting Tag Response Decoder

This block receives a contactless tag's reply, up to 32 bits long, from a single digitized demodulator line. The tag sends a one as a burst of subcarrier transitions and a zero as a quiet bit period. The block therefore does not sample a level per bit. It counts how many times the synchronized input changes level inside each fixed bit window. It turns that count into a bit, and folds the bit into a word that was preloaded with keystream. The result is the received bits XOR the keystream. With the keystream switched off, the result is the plain bits.

Timing is taken from a shared free-running timestamp. The reader side pulses `start_i` together with the timestamp at which its own outgoing frame ended. Listening begins a fixed guard time after that timestamp, not after the arming strobe, so only the part of the guard that is still left is actually waited. Bit windows then follow one another at an exact fixed step. After the last window closes, the assembled word and the clamped bit count are presented with a one-cycle valid pulse. They stay unchanged until the next accepted start.

Top module: `edge_tag_rx`

## Requirements
- R1: While reset is asserted and just after it is released, `rx_valid_o` is 0, `rx_data_o` is 0 and `rx_bits_o` is 0.
- R2: The first bit window opens on the cycle where `time_now_i` reaches `frame_end_ts_i + GUARD_T` (default 258). If that time has already passed when the start is accepted, the window opens on the first cycle after the start.
- R3: Each bit window lasts exactly `WIN_T` timestamp units (default 92). Window i closes when `time_now_i` equals the first window's opening time plus `WIN_T*(i+1)`, with no accumulated drift.
- R4: Every level change of the input, after a two-stage synchronizer, adds one to the edge count of the window it falls in. The count starts again from zero for each window.
- R5: A window whose edge count is strictly greater than 20 and strictly less than 60 decodes as a one. Any other count, including 20 and 60, decodes as a zero.
- R6: The edge counter saturates at its maximum (63 for the default 6-bit width) and never wraps. A very noisy window therefore decodes as a zero.
- R7: At start the data word is preloaded with `ks_word_i` when `ks_en_i` is 1, and with zero when `ks_en_i` is 0. Each decoded one inverts its bit of that word.
- R8: Bits are assembled least-significant first. Window 0 affects bit 0 of `rx_data_o`, window 1 affects bit 1, and so on.
- R9: A requested count `req_bits_i` above 32 is clamped to 32. `rx_bits_o` reports the count actually used.
- R10: `rx_valid_o` is high for exactly one cycle, starting in the cycle after the last window closes. With a count of 0 it starts in the cycle after the first window would open. `rx_data_o` then holds its value until the next accepted start.
- R11: A start pulse that arrives while a reception is in progress is ignored. It does not change the result or the number of valid pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Arms one reception (accepted only when idle) |
| frame_end_ts_i | input | 32 | Timestamp at which the reader frame ended |
| time_now_i | input | 32 | Shared free-running timestamp |
| req_bits_i | input | 8 | Number of reply bits expected |
| ks_word_i | input | 32 | Keystream word to preload |
| ks_en_i | input | 1 | 1 = preload keystream, 0 = preload zero |
| din_i | input | 1 | Digitized demodulator line (asynchronous) |
| rx_data_o | output | 32 | Decoded word, LSB first |
| rx_bits_o | output | 6 | Bit count in use (clamped) |
| rx_valid_o | output | 1 | One-cycle pulse when the word is complete |

## Verification
One frame feeds a set of per-window transition counts chosen to straddle both thresholds: 0, 20, 21, 42, 59, 60, plus a burst of 70 that overruns the counter. This separates an exclusive comparison from an inclusive one and shows whether the counter saturates or wraps. Further frames change the keystream preload (on, off while a nonzero word is offered, and with a zero-length reply) and the bit count (12, an oversized request that must clamp, and zero). They also place the frame-end timestamp both ahead of and behind the start, to tell a guard measured from the frame end apart from one measured from arming. The time at which the valid pulse appears is checked against the window arithmetic, and a start injected mid-reception must leave that frame's result unchanged.

// File: rtl/edge_dec_pkg.sv
package edge_dec_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_GUARD = 2'd1,
    ST_RX    = 2'd2,
    ST_DONE  = 2'd3
  } dec_state_e;

endpackage

// File: rtl/edr_sync_edge.sv
module edr_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din_i,
  output logic edge_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_n;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_single
      assign chain_n = din_i;
    end else begin : g_multi
      assign chain_n = {chain_q[STAGES-2:0], din_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= chain_n;
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign edge_o = chain_q[STAGES-1] ^ prev_q;

endmodule

// File: rtl/edr_edge_counter.sv
module edr_edge_counter #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic             edge_i,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_n;
  logic             cnt_upd;

  always_comb begin
    cnt_upd = clr_i | en_i;
    cnt_n   = cnt_q;
    if (clr_i) begin
      cnt_n = edge_i ? CNT_W'(1) : '0;
    end else if (en_i && edge_i && (cnt_q != CNT_MAX)) begin
      cnt_n = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_upd) begin
      cnt_q <= cnt_n;
    end
  end

  assign cnt_o = cnt_q;

  // R6: once at the ceiling the count stays there until a window restart
  p_cnt_saturate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && !clr_i) |=> (cnt_q == CNT_MAX));

  // R4: inside a window the count moves by at most one per cycle
  p_cnt_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i) |=> ((cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + CNT_W'(1))));

endmodule

// File: rtl/edr_bit_judge.sv
module edr_bit_judge #(
  parameter int CNT_W  = 6,
  parameter int ONE_LO = 20,
  parameter int ONE_HI = 60
) (
  input  logic [CNT_W-1:0] cnt_i,
  output logic             one_o
);

  localparam logic [CNT_W-1:0] LO_V = CNT_W'(ONE_LO);
  localparam logic [CNT_W-1:0] HI_V = CNT_W'(ONE_HI);

  always_comb begin
    one_o = (cnt_i > LO_V) && (cnt_i < HI_V);
  end

endmodule

// File: rtl/edge_tag_rx.sv
module edge_tag_rx
  import edge_dec_pkg::*;
#(
  parameter int TS_W     = 32,
  parameter int MAX_BITS = 32,
  parameter int REQ_W    = 8,
  parameter int GUARD_T  = 258,
  parameter int WIN_T    = 92,
  parameter int CNT_W    = 6,
  parameter int ONE_LO   = 20,
  parameter int ONE_HI   = 60,
  parameter int SYNC_N   = 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             start_i,
  input  logic [TS_W-1:0]                  frame_end_ts_i,
  input  logic [TS_W-1:0]                  time_now_i,
  input  logic [REQ_W-1:0]                 req_bits_i,
  input  logic [MAX_BITS-1:0]              ks_word_i,
  input  logic                             ks_en_i,
  input  logic                             din_i,
  output logic [MAX_BITS-1:0]              rx_data_o,
  output logic [$clog2(MAX_BITS+1)-1:0]    rx_bits_o,
  output logic                             rx_valid_o
);

  localparam int BCNT_W = $clog2(MAX_BITS + 1);
  localparam int IDX_W  = (MAX_BITS > 1) ? $clog2(MAX_BITS) : 1;
  localparam logic [TS_W-1:0]  GUARD_V = TS_W'(GUARD_T);
  localparam logic [TS_W-1:0]  WIN_V   = TS_W'(WIN_T);
  localparam logic [REQ_W-1:0] REQ_CAP = REQ_W'(MAX_BITS);

  dec_state_e            st_q, st_n;
  logic [TS_W-1:0]       dl_q, dl_n;
  logic [IDX_W-1:0]      idx_q, idx_n;
  logic [BCNT_W-1:0]     nbits_q, nbits_n;
  logic [MAX_BITS-1:0]   data_q, data_n;
  logic                  ctl_upd;

  logic [TS_W-1:0]       ts_diff;
  logic                  reached;
  logic                  last_bit;
  logic [BCNT_W-1:0]     req_clamped;

  logic                  edge_w;
  logic [CNT_W-1:0]      cnt_w;
  logic                  one_w;
  logic                  cnt_clr;
  logic                  cnt_en;

  // input conditioning and transition detection
  edr_sync_edge #(.STAGES(SYNC_N)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .din_i  (din_i),
    .edge_o (edge_w)
  );

  // per-window transition tally
  edr_edge_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (cnt_en),
    .clr_i  (cnt_clr),
    .edge_i (edge_w),
    .cnt_o  (cnt_w)
  );

  // count-to-bit decision
  edr_bit_judge #(.CNT_W(CNT_W), .ONE_LO(ONE_LO), .ONE_HI(ONE_HI)) u_judge (
    .cnt_i (cnt_w),
    .one_o (one_w)
  );

  // wrap-safe deadline comparison
  always_comb begin
    ts_diff  = time_now_i - dl_q;
    reached  = ~ts_diff[TS_W-1];
    last_bit = ((BCNT_W'(idx_q) + BCNT_W'(1)) == nbits_q);
    req_clamped = (req_bits_i > REQ_CAP) ? BCNT_W'(MAX_BITS) : BCNT_W'(req_bits_i);
  end

  // next-state logic
  always_comb begin
    st_n    = st_q;
    dl_n    = dl_q;
    idx_n   = idx_q;
    nbits_n = nbits_q;
    data_n  = data_q;
    cnt_clr = 1'b0;
    cnt_en  = (st_q == ST_RX);
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          nbits_n = req_clamped;
          data_n  = ks_en_i ? ks_word_i : '0;
          dl_n    = frame_end_ts_i + GUARD_V;
          idx_n   = '0;
          st_n    = ST_GUARD;
        end
      end
      ST_GUARD: begin
        if (reached) begin
          dl_n    = time_now_i + WIN_V;
          cnt_clr = 1'b1;
          st_n    = (nbits_q == '0) ? ST_DONE : ST_RX;
        end
      end
      ST_RX: begin
        if (reached) begin
          data_n[idx_q] = data_q[idx_q] ^ one_w;
          dl_n    = dl_q + WIN_V;
          cnt_clr = 1'b1;
          if (last_bit) begin
            st_n = ST_DONE;
          end else begin
            idx_n = idx_q + IDX_W'(1);
          end
        end
      end
      ST_DONE: begin
        st_n = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
    ctl_upd = (st_q != ST_IDLE) || start_i;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      dl_q    <= '0;
      idx_q   <= '0;
      nbits_q <= '0;
      data_q  <= '0;
    end else if (ctl_upd) begin
      st_q    <= st_n;
      dl_q    <= dl_n;
      idx_q   <= idx_n;
      nbits_q <= nbits_n;
      data_q  <= data_n;
    end
  end

  assign rx_data_o  = data_q;
  assign rx_bits_o  = nbits_q;
  assign rx_valid_o = (st_q == ST_DONE);

  // R10: the completion strobe never lasts two cycles
  p_valid_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o);

  // R10: the result stays put while no new reception is accepted
  p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && !start_i) |=> $stable(rx_data_o));

  // R9: the reported count never exceeds the word width
  p_bits_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_bits_o <= BCNT_W'(MAX_BITS));

  // R11: a start seen mid-reception leaves the active count untouched
  p_busy_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && (st_q == ST_GUARD || st_q == ST_RX)) |=> $stable(rx_bits_o));

  // R3: window boundaries advance by exactly one window length
  p_window_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RX && reached && !last_bit) |=> (dl_q == $past(dl_q) + WIN_V));

endmodule

// File: tb/edge_tag_rx_tb.sv
`timescale 1ns/1ps
module edge_tag_rx_tb;

  localparam int GUARD = 258;
  localparam int WIN   = 92;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [31:0] frame_end_ts_i;
  logic [31:0] time_now_i;
  logic [7:0]  req_bits_i;
  logic [31:0] ks_word_i;
  logic        ks_en_i;
  logic        din_i;
  logic [31:0] rx_data_o;
  logic [5:0]  rx_bits_o;
  logic        rx_valid_o;

  int cyc;
  int n_chk;
  int n_fail;

  logic [31:0] q_data[$];
  int          q_bits[$];
  int          q_time[$];

  edge_tag_rx u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .frame_end_ts_i (frame_end_ts_i),
    .time_now_i     (time_now_i),
    .req_bits_i     (req_bits_i),
    .ks_word_i      (ks_word_i),
    .ks_en_i        (ks_en_i),
    .din_i          (din_i),
    .rx_data_o      (rx_data_o),
    .rx_bits_o      (rx_bits_o),
    .rx_valid_o     (rx_valid_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;
  assign time_now_i = 32'(cyc);

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: compare each completed word with the scoreboard head
  always @(posedge clk) begin
    #1;
    if (rst_n && rx_valid_o) begin
      if (q_data.size() == 0) begin
        check(1'b0, "R11 unexpected valid pulse", 32'(cyc), 32'hFFFFFFFF);
      end else begin
        logic [31:0] ed;
        int eb;
        int et;
        ed = q_data.pop_front();
        eb = q_bits.pop_front();
        et = q_time.pop_front();
        check(rx_data_o == ed, "R5 R7 R8 decoded data", rx_data_o, ed);
        check(int'(rx_bits_o) == eb, "R9 bit count", 32'(rx_bits_o), 32'(eb));
        check(cyc == et, "R2 R3 R10 valid timing", 32'(cyc), 32'(et));
      end
    end
  end

  // driver: arm one reception, play per-window transition bursts, predict result
  task automatic run_frame(input int ref_off, input int req, input logic [31:0] ks,
                           input logic ks_en, input int k[32], input bit poke);
    int s;
    int n;
    int tgt;
    int e;
    logic [31:0] exp_d;
    @(negedge clk);
    s = cyc;
    start_i        = 1'b1;
    frame_end_ts_i = 32'(s + ref_off);
    req_bits_i     = 8'(req);
    ks_word_i      = ks;
    ks_en_i        = ks_en;
    n   = (req > 32) ? 32 : req;
    tgt = s + ref_off + GUARD;
    e   = (tgt > s + 1) ? tgt : s + 1;
    exp_d = ks_en ? ks : 32'h0;
    for (int i = 0; i < n; i++) begin
      int kk;
      kk = (k[i] > 63) ? 63 : k[i];
      if (kk > 20 && kk < 60) exp_d[i] = ~exp_d[i];
    end
    q_data.push_back(exp_d);
    q_bits.push_back(n);
    q_time.push_back(e + WIN * n + 1);
    @(negedge clk);
    while (cyc <= e + WIN * n + 4) begin
      int off;
      start_i = 1'b0;
      off = cyc - e;
      if (off >= 0) begin
        int wi;
        int r;
        wi = off / WIN;
        r  = off % WIN;
        if (wi < n && r >= 10 && r < 10 + k[wi]) din_i = ~din_i;
      end
      if (poke && cyc == e + 150) begin
        start_i        = 1'b1;
        frame_end_ts_i = 32'(cyc);
        req_bits_i     = 8'd3;
        ks_word_i      = 32'hFFFF0000;
        ks_en_i        = 1'b1;
      end
      @(negedge clk);
    end
    start_i = 1'b0;
    repeat (3) @(negedge clk);
    check(rx_data_o == exp_d, "R10 data held after valid", rx_data_o, exp_d);
    check(q_data.size() == 0, "R10 valid pulse issued", 32'(q_data.size()), 32'd0);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int k[32];
    n_chk = 0;
    n_fail = 0;
    rst_n = 1'b0;
    start_i = 1'b0;
    frame_end_ts_i = '0;
    req_bits_i = '0;
    ks_word_i = '0;
    ks_en_i = 1'b0;
    din_i = 1'b0;
    repeat (4) @(negedge clk);
    // R1 during reset
    check(rx_valid_o == 1'b0, "R1 valid in reset", 32'(rx_valid_o), 32'd0);
    check(rx_data_o == 32'h0, "R1 data in reset", rx_data_o, 32'h0);
    check(rx_bits_o == 6'd0, "R1 count in reset", 32'(rx_bits_o), 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(rx_valid_o == 1'b0 && rx_data_o == 32'h0, "R1 idle after reset", rx_data_o, 32'h0);

    // thresholds and saturation, plain bits, future frame end (R4 R5 R6 R8)
    foreach (k[i]) k[i] = 0;
    k[0] = 42; k[1] = 0; k[2] = 21; k[3] = 20;
    k[4] = 59; k[5] = 60; k[6] = 70; k[7] = 30;
    run_frame(50, 8, 32'h0, 1'b0, k, 1'b0);

    // keystream preload with alternating pattern (R7)
    foreach (k[i]) k[i] = (i % 2 == 0) ? 42 : 5;
    run_frame(20, 12, 32'hA5A5F00F, 1'b1, k, 1'b0);

    // oversized request clamps to full word (R9)
    foreach (k[i]) k[i] = (i % 3 == 0) ? 40 : 10;
    run_frame(0, 40, 32'h12345678, 1'b1, k, 1'b0);

    // frame end long past: listen at once; keystream offered but disabled (R2 R7)
    foreach (k[i]) k[i] = (i == 1 || i == 4) ? 33 : 2;
    run_frame(-400, 5, 32'hFFFFFFFF, 1'b0, k, 1'b0);

    // zero-length reply returns preload right after guard (R10)
    foreach (k[i]) k[i] = 0;
    run_frame(10, 0, 32'h0BADF00D, 1'b1, k, 1'b0);

    // start injected mid-reception is ignored (R11)
    foreach (k[i]) k[i] = (i < 3) ? 25 : 55;
    run_frame(30, 6, 32'h00000030, 1'b1, k, 1'b1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule